// File: doc/BRIEF.md
# Activation Sign Packer with Mean-Magnitude Scale

The block sits in front of a bitwise (XNOR and population-count) datapath. It accepts a stream of signed two's-complement activations that together form one slice of `SLICE_N` elements, with a marker on the final element. Each value is reduced to one sign bit. The bits are gathered into words of `WORD_W` bits, which leave on a separate valid/ready stream together with a count of how many bits in the word are meaningful.

In the same pass the block adds up the magnitudes of the slice. When the slice closes, it divides the total by the element count to give a fixed-point scale factor with `FRAC` fractional bits. The division is a multiply by a reciprocal that is computed at elaboration time. The scale appears with a one-cycle strobe and then stays put until the next slice closes. A downstream stage uses this scale to restore the dynamic range of the binary products.

The input stalls whenever a finished word is waiting and the output is not taking it. Samples are therefore never dropped or repeated.

Top module: `sign_pack_scaler`

## Requirements
- R1: A sample whose sign bit is clear, zero included, becomes packed bit 1. A sample whose sign bit is set becomes packed bit 0.
- R2: The first sample accepted after a word boundary lands in bit 0, and each later sample takes the next higher bit. A word is emitted as soon as `WORD_W` bits are held. `WORD_W` is 32 or 64.
- R3: The sample flagged as last closes the word in progress. Bits above the filled ones are zero, and `out_count` gives the filled bit count. Full words report `out_count` = `WORD_W`.
- R4: `scale` equals floor(sum of |sample| × 2^FRAC / SLICE_N) over the elements of the slice.
- R5: `scale_valid` is high for exactly one cycle, the cycle after the last sample is accepted. `scale` keeps its value until the next slice closes.
- R6: A slice made entirely of the most negative value gives the exact scale 2^(DATA_W-1) × 2^FRAC, with no wrap.
- R7: While `out_valid` is high and `out_ready` is low, `out_word` and `out_count` stay unchanged and `in_ready` is low. Every accepted sample appears exactly once in the output words.
- R8: After reset, `out_valid` = 0, `scale_valid` = 0, `scale` = 0 and `in_ready` = 1.
- R9: Each slice starts its sum and its bit packing from zero, so the previous slice has no effect on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | DATA_W | Signed two's-complement sample |
| in_last | input | 1 | Sample is the final one of the slice |
| out_valid | output | 1 | Packed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | WORD_W | Sign bits, earliest sample in bit 0 |
| out_count | output | $clog2(WORD_W+1) | Number of meaningful bits in `out_word` |
| scale_valid | output | 1 | One-cycle strobe for a new scale |
| scale | output | DATA_W+FRAC | Mean magnitude, FRAC fractional bits |

## Verification
The final sample of a slice does two things in the same cycle: it pushes the zero-padded partial word into the output register, and it closes the sum that produces the scale strobe. A slice run with `out_ready` toggling on a three-cycle pattern forces this to happen while the previous word is still stalled. The bench then checks two things. First, the strobe still follows the last acceptance by exactly one cycle. Second, the padded word, its count and every stalled word come out unchanged and in order.

// File: rtl/sign_pack_pkg.sv
package sign_pack_pkg;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_WORD_W  = 32;
    localparam int DEF_SLICE_N = 40;
    localparam int DEF_FRAC    = 8;

    // rounded-up integer quotient, used for the reciprocal constant
    function automatic longint unsigned ceil_div(longint unsigned num, longint unsigned den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/spk_packer.sv
module spk_packer #(
    parameter int WORD_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  logic                        bit_in,
    input  logic                        close,
    input  logic                        out_ready,
    output logic                        in_ready,
    output logic                        out_valid,
    output logic [WORD_W-1:0]           out_word,
    output logic [$clog2(WORD_W+1)-1:0] out_count
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] shift;
        logic [CNT_W-1:0]  fill;
        logic [WORD_W-1:0] obuf;
        logic [CNT_W-1:0]  ocnt;
        logic              ovalid;
    } pk_t;

    pk_t               s_d, s_q;
    logic [WORD_W-1:0] merged_d;

    always_comb begin
        s_d      = s_q;
        merged_d = s_q.shift | (WORD_W'(bit_in) << s_q.fill);
        if (s_q.ovalid && out_ready) begin
            s_d.ovalid = 1'b0;
        end
        if (take) begin
            if ((s_q.fill == CNT_W'(WORD_W - 1)) || close) begin
                s_d.obuf   = merged_d;
                s_d.ocnt   = s_q.fill + 1'b1;
                s_d.ovalid = 1'b1;
                s_d.shift  = '0;
                s_d.fill   = '0;
            end else begin
                s_d.shift = merged_d;
                s_d.fill  = s_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = !s_q.ovalid || out_ready;
    assign out_valid = s_q.ovalid;
    assign out_word  = s_q.obuf;
    assign out_count = s_q.ocnt;

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_count)));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_count != '0 && out_count <= CNT_W'(WORD_W)));
endmodule

// File: rtl/spk_scaler.sv
module spk_scaler #(
    parameter int DATA_W  = 16,
    parameter int SLICE_N = 40,
    parameter int FRAC    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   take,
    input  logic [DATA_W-1:0]      sample,
    input  logic                   close,
    output logic                   scale_valid,
    output logic [DATA_W+FRAC-1:0] scale
);
    localparam int SUM_W   = DATA_W + $clog2(SLICE_N + 1);
    localparam int X_W     = SUM_W + FRAC;
    localparam int SH      = X_W + $clog2(SLICE_N) + 1;
    localparam int RECIP_W = SH + 1;
    localparam int PROD_W  = X_W + RECIP_W;
    localparam int SCALE_W = DATA_W + FRAC;
    localparam logic [RECIP_W-1:0] RECIP =
        RECIP_W'(sign_pack_pkg::ceil_div(64'd1 << SH, 64'(SLICE_N)));
    localparam logic [SUM_W-1:0] SUM_MAX = SUM_W'(SLICE_N) << (DATA_W - 1);

    typedef struct packed {
        logic [SUM_W-1:0]   sum;
        logic [SCALE_W-1:0] scale;
        logic               sv;
    } sc_t;

    sc_t               s_d, s_q;
    logic [DATA_W-1:0] mag_d;
    logic [SUM_W-1:0]  sum_next_d;
    logic [X_W-1:0]    xval_d;

    always_comb begin
        s_d        = s_q;
        s_d.sv     = 1'b0;
        mag_d      = sample[DATA_W-1] ? (~sample + 1'b1) : sample;
        sum_next_d = s_q.sum + SUM_W'(mag_d);
        xval_d     = {sum_next_d, {FRAC{1'b0}}};
        if (take) begin
            if (close) begin
                s_d.scale = SCALE_W'((PROD_W'(xval_d) * PROD_W'(RECIP)) >> SH);
                s_d.sv    = 1'b1;
                s_d.sum   = '0;
            end else begin
                s_d.sum = sum_next_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign scale_valid = s_q.sv;
    assign scale       = s_q.scale;

    // R6
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sum <= SUM_MAX);

    // R5
    scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scale_valid |-> $stable(scale));

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scale_valid |=> !scale_valid);
endmodule

// File: rtl/sign_pack_scaler.sv
module sign_pack_scaler #(
    parameter int DATA_W  = sign_pack_pkg::DEF_DATA_W,
    parameter int WORD_W  = sign_pack_pkg::DEF_WORD_W,
    parameter int SLICE_N = sign_pack_pkg::DEF_SLICE_N,
    parameter int FRAC    = sign_pack_pkg::DEF_FRAC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [DATA_W-1:0]           in_data,
    input  logic                        in_last,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [WORD_W-1:0]           out_word,
    output logic [$clog2(WORD_W+1)-1:0] out_count,
    output logic                        scale_valid,
    output logic [DATA_W+FRAC-1:0]      scale
);
    logic take;
    logic sign_bit;

    assign take     = in_valid && in_ready;
    assign sign_bit = ~in_data[DATA_W-1];

    spk_packer #(.WORD_W(WORD_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .bit_in    (sign_bit),
        .close     (in_last),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_count (out_count)
    );

    spk_scaler #(.DATA_W(DATA_W), .SLICE_N(SLICE_N), .FRAC(FRAC)) u_scale (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .sample      (in_data),
        .close       (in_last),
        .scale_valid (scale_valid),
        .scale       (scale)
    );

    // R5
    strobe_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scale_valid |-> $past(in_valid && in_ready && in_last));
endmodule

// File: tb/sign_pack_scaler_test.sv
module sign_pack_scaler_test;
    localparam int DW = 16;
    localparam int WW = 32;
    localparam int N  = 40;
    localparam int FR = 8;
    localparam int CW = $clog2(WW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_last = 1'b0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [WW-1:0] out_word;
    logic [CW-1:0] out_count;
    logic          scale_valid;
    logic [DW+FR-1:0] scale;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit bp_mode = 1'b0;

    logic [WW-1:0]    got_w [0:15];
    int               got_c [0:15];
    int               n_got = 0;
    int               n_sc = 0;
    int               sc_cyc = 0;
    int               last_cyc = -10;
    logic [DW+FR-1:0] sc_val = '0;
    logic signed [DW-1:0] vals [0:N-1];
    bit               prev_stall = 1'b0;
    logic [WW-1:0]    held_w = '0;
    logic [CW-1:0]    held_c = '0;

    sign_pack_scaler #(.DATA_W(DW), .WORD_W(WW), .SLICE_N(N), .FRAC(FR)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_word(out_word), .out_count(out_count),
        .scale_valid(scale_valid), .scale(scale)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (prev_stall) begin
                // R7 stalled word must not move
                chk(out_valid && out_word == held_w && out_count == held_c, "R7 hold",
                    longint'(out_word), longint'(held_w));
            end
            if (out_valid && !out_ready) begin
                chk(!in_ready, "R7 stall", longint'(in_ready), 0);
            end
            prev_stall = out_valid && !out_ready;
            held_w = out_word;
            held_c = out_count;
            if (out_valid && out_ready && n_got < 16) begin
                got_w[n_got] = out_word;
                got_c[n_got] = int'(out_count);
                n_got++;
            end
            if (in_valid && in_ready && in_last) last_cyc = cyc;
            if (scale_valid) begin
                n_sc++;
                sc_cyc = cyc;
                sc_val = scale;
            end
        end
    end

    always @(negedge clk) begin
        out_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;
    end

    function automatic logic signed [DW-1:0] gen(input int p, input int i);
        case (p)
            0: case (i % 4)
                   0: return '0;
                   1: return DW'(-(i * 37));
                   2: return DW'(i * 91);
                   default: return (i % 8 == 3) ? DW'(-1) : DW'(1000 - i);
               endcase
            1: return DW'(-32768);
            2: return DW'(i + 1);
            default: return (i % 2 == 1) ? DW'(32767) : DW'(-5);
        endcase
    endfunction

    task automatic send_slice(input int p, input int gap);
        bit ok;
        n_got = 0;
        n_sc  = 0;
        for (int i = 0; i < N; i++) vals[i] = gen(p, i);
        for (int i = 0; i < N; i++) begin
            if (gap > 0 && i % gap == 1) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = vals[i];
            in_last  = (i == N - 1);
            ok = 1'b0;
            while (!ok) begin
                #5;
                ok = in_ready;
                @(posedge clk);
                if (!ok) @(negedge clk);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (20) @(negedge clk);
    endtask

    task automatic check_slice(input string tag);
        logic [WW-1:0] ew;
        int  ec;
        longint sum;
        longint escale;
        sum = 0;
        for (int i = 0; i < N; i++) sum += (vals[i] < 0) ? -longint'(vals[i]) : longint'(vals[i]);
        escale = (sum * (64'd1 << FR)) / N;
        chk(n_got == (N + WW - 1) / WW, {tag, " R7 word count"}, n_got, (N + WW - 1) / WW);
        for (int w = 0; w < (N + WW - 1) / WW; w++) begin
            ew = '0;
            ec = 0;
            for (int j = 0; j < WW; j++) begin
                if (w * WW + j < N) begin
                    ew[j] = (vals[w * WW + j] >= 0);
                    ec++;
                end
            end
            // R2 bit order, R3 zero padding
            chk(got_w[w] == ew, {tag, " R2 R3 word"}, longint'(got_w[w]), longint'(ew));
            chk(got_c[w] == ec, {tag, " R3 count"}, got_c[w], ec);
        end
        chk(longint'(sc_val) == escale, {tag, " R4 scale"}, longint'(sc_val), escale);
        chk(n_sc == 1, {tag, " R5 pulse count"}, n_sc, 1);
        chk(sc_cyc == last_cyc + 1, {tag, " R5 pulse timing"}, sc_cyc, last_cyc + 1);
        chk(scale == sc_val, {tag, " R5 scale held"}, longint'(scale), longint'(sc_val));
    endtask

    task automatic t_reset;
        #5;
        chk(out_valid == 1'b0, "R8 out_valid", longint'(out_valid), 0);
        chk(scale_valid == 1'b0, "R8 scale_valid", longint'(scale_valid), 0);
        chk(scale == '0, "R8 scale", longint'(scale), 0);
        chk(in_ready == 1'b1, "R8 in_ready", longint'(in_ready), 1);
    endtask

    task automatic t_mixed;
        bp_mode = 1'b0;
        send_slice(0, 0);
        check_slice("mixed");
        // R1: element 0 is zero and must map to 1, element 1 is negative and maps to 0
        chk(got_w[0][0] == 1'b1, "R1 zero sign", longint'(got_w[0][0]), 1);
        chk(got_w[0][1] == 1'b0, "R1 negative sign", longint'(got_w[0][1]), 0);
    endtask

    task automatic t_most_negative;
        bp_mode = 1'b0;
        send_slice(1, 0);
        check_slice("minval");
        chk(longint'(sc_val) == (longint'(1) << (DW - 1 + FR)), "R6 full scale",
            longint'(sc_val), longint'(1) << (DW - 1 + FR));
        chk(got_w[0] == '0, "R1 all negative", longint'(got_w[0]), 0);
    endtask

    task automatic t_backpressure;
        bp_mode = 1'b1;
        send_slice(3, 5);
        bp_mode = 1'b0;
        repeat (4) @(negedge clk);
        check_slice("stall R7");
    endtask

    task automatic t_independent;
        bp_mode = 1'b0;
        send_slice(3, 0);
        send_slice(2, 0);
        // R9: small positive slice right after a large one
        check_slice("second R9");
        chk(longint'(sc_val) == (longint'(820) * 256) / N, "R9 sum cleared",
            longint'(sc_val), (longint'(820) * 256) / N);
        repeat (10) @(negedge clk);
        chk(scale == sc_val, "R5 later hold", longint'(scale), longint'(sc_val));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_mixed();
        t_most_negative();
        t_backpressure();
        t_independent();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule